// File: doc/BRIEF.md
# Programmable Reload Interval Timer

The block is a 16-bit down-counting interval timer. A free-running phase counter divides the peripheral clock by a power of two picked by a 4-bit code, and each divided pulse moves the counter down by one while the timer runs. When the counter passes zero it takes the reload value again and raises an interrupt flag. In one-shot mode the timer then stops by itself. In repeat mode it keeps counting.

Software reaches five 16-bit registers through a small register bus: divide select, reload value, live count, control, and interrupt. A write of 1 to the control register's restart bit loads the count from the reload register and starts the divider phase again from zero. The single interrupt output is the flag gated by an enable.

Top module: `reload_timer`

## Requirements
- R1: Divide code k (0x0 to 0xe, field bits [3:0] at byte address 0x0) makes one count step every 2^k clocks while running. After a restart, the first underflow lands exactly (reload+1)*2^k clock edges after the edge that sets the run bit.
- R2: Divide code 0xf halts counting: the counter holds its value and no underflow occurs, even with the run bit set.
- R3: Register byte addresses are 0x2 for reload (read/write, resets to 0x0000) and 0x4 for the counter (read-only, resets to 0xffff). The divide select at 0x0, control at 0x6 and interrupt at 0x8 all reset to 0.
- R4: On underflow (a count step while the counter is 0), the counter takes the reload value and the interrupt flag is set.
- R5: Control bit 4 selects one-shot (1) or repeat (0). In one-shot mode an underflow clears run bit 0. In repeat mode run stays 1.
- R6: Writing 1 to control bit 1 loads the counter from the reload register and zeroes the divider phase. Writing 0 to it leaves the counter unchanged. The bit always reads back as 0.
- R7: While run bit 0 is 0, the counter holds its value.
- R8: The interrupt flag (interrupt register bit 0) is cleared only by writing 1 to it. Writing 0 has no effect. If an underflow and a clearing write fall in the same cycle, the set wins.
- R9: `irq_o` is high exactly when the flag and the enable (interrupt register bit 8) are both 1. It rises on the same edge that sets the flag.
- R10: Bits with no function read as 0. Read data is registered and shows the addressed register as it stood at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The main count path is run with a table of divide codes and reload values in both modes, and the bench measures the clock count from the run edge to the interrupt. These runs include the smallest reload of zero, an undivided clock, and the largest divide of 16384, so an off-by-one error in either the divider or the counter shows up as a wrong period. The one-shot entries and the repeat entries differ only in the run bit read back afterwards, which separates mode handling from the counting itself. Directed cases cover the reserved code, restart writes of 0 and of 1, and the flag and enable combinations.

// File: rtl/rlt_pkg.sv
package rlt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int CODE_W = 4;
  localparam int DIV_W  = 14;

  localparam logic [ADDR_W-1:0] A_DIV  = 4'h0;
  localparam logic [ADDR_W-1:0] A_RLD  = 4'h2;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'h4;
  localparam logic [ADDR_W-1:0] A_CTL  = 4'h6;
  localparam logic [ADDR_W-1:0] A_INT  = 4'h8;

  localparam int B_RUN     = 0;
  localparam int B_RESTART = 1;
  localparam int B_MODE    = 4;
  localparam int B_FLAG    = 0;
  localparam int B_EN      = 8;
endpackage

// File: rtl/rlt_prescaler.sv
module rlt_prescaler #(
  parameter int DIV_W  = 14,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam logic [CODE_W-1:0] CODE_RSV = '1;

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] mask;
  logic             active;

  always_comb begin
    active = run_i && (code_i != CODE_RSV);
    mask   = DIV_W'((32'd1 << code_i) - 32'd1);
    tick_o = active && ((phase_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || restart_i) phase_q <= '0;
    else if (active)      phase_q <= phase_q + 1'b1;
  end

  AST_RSV_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (code_i == CODE_RSV) |-> !tick_o); // R2
endmodule

// File: rtl/rlt_counter.sv
module rlt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         uflow_o
);
  always_comb uflow_o = tick_i && !restart_i && (cnt_o == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt_o <= '1;
    else if (restart_i) cnt_o <= reload_i;
    else if (uflow_o)   cnt_o <= reload_i;
    else if (tick_i)    cnt_o <= cnt_o - 1'b1;
  end

  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (rst)
    uflow_o |=> (cnt_o == $past(reload_i))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !restart_i) |=> $stable(cnt_o)); // R7
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rlt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] cnt;
  logic              mode_q, run_q, run_d;
  logic              flag_q, flag_d, en_q, en_d;
  logic              tick, uflow, restart;
  logic              wr_div, wr_rld, wr_ctl, wr_int;

  always_comb begin
    wr_div  = bus_we && (bus_addr == A_DIV);
    wr_rld  = bus_we && (bus_addr == A_RLD);
    wr_ctl  = bus_we && (bus_addr == A_CTL);
    wr_int  = bus_we && (bus_addr == A_INT);
    restart = wr_ctl && bus_wdata[B_RESTART];

    run_d = run_q;
    if (uflow && mode_q) run_d = 1'b0;
    if (wr_ctl)          run_d = bus_wdata[B_RUN];

    flag_d = flag_q;
    if (wr_int && bus_wdata[B_FLAG]) flag_d = 1'b0;
    if (uflow)                       flag_d = 1'b1;
    en_d = wr_int ? bus_wdata[B_EN] : en_q;
  end

  rlt_prescaler #(.DIV_W(DIV_W), .CODE_W(CODE_W)) u_presc (
    .clk(clk), .rst(rst), .run_i(run_q), .restart_i(restart),
    .code_i(code_q), .tick_o(tick)
  );

  rlt_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .restart_i(restart), .tick_i(tick),
    .reload_i(reload_q), .cnt_o(cnt), .uflow_o(uflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      reload_q <= '0;
      mode_q   <= 1'b0;
      run_q    <= 1'b0;
      flag_q   <= 1'b0;
      en_q     <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      if (wr_div) code_q   <= bus_wdata[CODE_W-1:0];
      if (wr_rld) reload_q <= bus_wdata;
      if (wr_ctl) mode_q   <= bus_wdata[B_MODE];
      run_q  <= run_d;
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_o  <= flag_d && en_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      bus_rdata <= '0;
      case (bus_addr)
        A_DIV: bus_rdata[CODE_W-1:0] <= code_q;
        A_RLD: bus_rdata <= reload_q;
        A_CNT: bus_rdata <= cnt;
        A_CTL: begin
          bus_rdata[B_MODE] <= mode_q;
          bus_rdata[B_RUN]  <= run_q;
        end
        A_INT: begin
          bus_rdata[B_EN]   <= en_q;
          bus_rdata[B_FLAG] <= flag_q;
        end
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (uflow && mode_q && !wr_ctl) |=> !run_q); // R5
  AST_REPEAT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (uflow && !mode_q && !wr_ctl) |=> run_q); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_int && bus_wdata[B_FLAG])) |=> flag_q); // R8
  AST_UF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    uflow |=> flag_q); // R4
  AST_EN_GATES: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !irq_o); // R9
endmodule

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  reload_timer u_reload_timer (.*);

  // vector: {code[3:0], reload[15:0], one_shot}
  localparam logic [20:0] VEC [7] = '{
    {4'h0, 16'd0, 1'b1}, {4'h0, 16'd5, 1'b1}, {4'h1, 16'd3, 1'b0},
    {4'h3, 16'd2, 1'b1}, {4'h2, 16'd7, 1'b0}, {4'he, 16'd0, 1'b1},
    {4'h5, 16'd1, 1'b0}
  };

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a;
    @(posedge clk); #1 d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, held;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // reset state
    chk("R9 irq after reset", irq_o, 0);
    rd(4'h0, v); chk("R3 divide reset", v, 16'h0000);
    rd(4'h2, v); chk("R3 reload reset", v, 16'h0000);
    rd(4'h4, v); chk("R3 counter reset", v, 16'hffff);
    rd(4'h6, v); chk("R3 control reset", v, 16'h0000);
    rd(4'h8, v); chk("R3 interrupt reset", v, 16'h0000);

    // table walk: period and mode
    foreach (VEC[i]) begin
      logic [3:0] code; logic [15:0] rl; logic os;
      {code, rl, os} = VEC[i];
      wr(4'h0, {12'h0, code});
      wr(4'h2, rl);
      wr(4'h8, 16'h0101);
      wr(4'h6, {11'h0, os, 4'b0010});
      wr(4'h6, {11'h0, os, 4'b0001});
      n = 0;
      while (!irq_o && n < 40000) begin @(posedge clk); #1 n++; end
      chk($sformatf("R1 R4 period code %0h reload %0d", code, rl), n, (rl + 1) << code);
      rd(4'h6, v);
      if (os) begin
        chk("R5 one-shot clears run", v, 16'h0010);
        rd(4'h4, v); chk("R4 counter reloaded", v, rl);
      end else begin
        chk("R5 repeat keeps run", v, 16'h0001);
        wr(4'h6, 16'h0000);
      end
      rd(4'h8, v); chk("R9 R4 flag and enable", v, 16'h0101);
    end

    // R2: reserved divide code halts counting
    wr(4'h8, 16'h0101);
    wr(4'h0, 16'h000f); wr(4'h2, 16'd2);
    wr(4'h6, 16'h0002); wr(4'h6, 16'h0001);
    repeat (100) @(posedge clk);
    #1 chk("R2 no irq with reserved code", irq_o, 0);
    wr(4'h6, 16'h0000);
    rd(4'h4, v); chk("R2 counter held", v, 16'd2);

    // R10: unused bits read 0
    wr(4'h0, 16'hffff); rd(4'h0, v); chk("R10 divide field only", v, 16'h000f);
    wr(4'h8, 16'hffff); rd(4'h8, v); chk("R10 interrupt bits only", v, 16'h0100);
    rd(4'ha, v); chk("R10 unmapped address", v, 16'h0000);

    // R6/R7: restart bit 0 vs 1, stopped counter holds
    wr(4'h0, 16'h0000); wr(4'h2, 16'd9);
    wr(4'h6, 16'h0002); wr(4'h6, 16'h0001);
    repeat (3) @(posedge clk);
    wr(4'h6, 16'h0000);
    rd(4'h4, held);
    chk("R7 counter moved before stop", (held < 16'd9), 1);
    wr(4'h2, 16'd20);
    wr(4'h6, 16'h0000);
    repeat (10) @(posedge clk);
    rd(4'h4, v); chk("R6 R7 restart 0 keeps count", v, held);
    wr(4'h6, 16'h0002);
    rd(4'h4, v); chk("R6 restart 1 loads reload", v, 16'd20);
    rd(4'h6, v); chk("R6 restart bit reads 0", v, 16'h0000);

    // R8/R9: flag clearing and enable gating
    wr(4'h8, 16'h0001);
    wr(4'h2, 16'd1);
    wr(4'h6, 16'h0012); wr(4'h6, 16'h0011);
    repeat (10) @(posedge clk);
    #1 chk("R9 flag without enable", irq_o, 0);
    rd(4'h8, v); chk("R8 flag set", v, 16'h0001);
    wr(4'h8, 16'h0000);
    rd(4'h8, v); chk("R8 write 0 keeps flag", v, 16'h0001);
    wr(4'h8, 16'h0100);
    #1 chk("R9 enable raises irq", irq_o, 1);
    wr(4'h8, 16'h0101);
    rd(4'h8, v); chk("R8 write 1 clears flag", v, 16'h0100);
    chk("R9 irq drops with flag", irq_o, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule